// File: doc/BRIEF.md
# Display Gamma and Color Matrix Pipeline

This block sits in the pixel path of a display output channel. Each valid 24-bit RGB pixel is first remapped, one component at a time, through a programmable 256-entry gamma table. The three remapped components then go through a 3x3 color matrix with signed fixed-point coefficients. Each matrix output is clamped to an 8-bit component. Timing generation, blending and overlays happen elsewhere.

Software hands the block wide coefficients: 64-bit signed-magnitude numbers with 32 fractional bits. A converter on the load port turns each one into a 10-bit two's complement value with 8 fractional bits. When the magnitude is too large to represent, the converter pins it at the largest representable value rather than keeping low-order bits. Coefficient and enable writes land in a shadow set. The shadow set becomes active only on a frame-start strobe, so a frame never uses a mix of old and new settings. With the matrix disabled, the gamma output passes straight through.

Top module: `clrx_gamma_matrix`

## Requirements
- R1: A pixel carries red in bits 23:16, green in 15:8 and blue in 7:0. Each component is replaced by the entry of its own gamma table addressed by the component value.
- R2: A gamma write with `lut_wr_sel` 0, 1 or 2 stores `lut_wr_data` at `lut_wr_addr` of the red, green or blue table. Select value 3 changes no table. A pixel sampled on a later edge than the write sees the new entry.
- R3: After reset, every table entry equals its address, the matrix is disabled in both the shadow and active sets, all coefficients are zero, and `pix_out_vld` is low.
- R4: A wide coefficient is converted as follows. Bit 63 is its sign. Bits 62:0, shifted right by 24, give the magnitude, which is limited to 511. The result is the negated magnitude when the sign is set. Magnitude 2.0 therefore becomes 511, not 0.
- R5: Coefficient index 0 to 8 selects, in order, red-from-red, red-from-green, red-from-blue, green-from-red, green-from-green, green-from-blue, blue-from-red, blue-from-green, blue-from-blue. A write with index 9 to 15 changes no coefficient.
- R6: With the matrix active, each output component is the sum of its row's three coefficient-times-gamma products, shifted arithmetically right by 8 (rounding toward minus infinity), and then limited to 0..255.
- R7: Coefficient and enable writes go only to the shadow set. A high `frame_start` copies the shadow set, as it stood before that edge, into the active set. Only the active set affects pixels.
- R8: While the active enable is clear, the output equals the gamma table output unchanged.
- R9: A pixel sampled at a rising edge leaves the block right after the second edge that follows. `pix_out_vld` repeats `pix_in_vld` with the same delay. The block has no backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lut_wr_en | input | 1 | Gamma table write strobe |
| lut_wr_sel | input | 2 | Table select: 0 red, 1 green, 2 blue, 3 none |
| lut_wr_addr | input | 8 | Table entry address |
| lut_wr_data | input | 8 | Table entry value |
| coef_wr_en | input | 1 | Coefficient write strobe into the shadow set |
| coef_wr_idx | input | 4 | Coefficient index, row-major |
| coef_wr_val | input | 64 | Wide signed-magnitude coefficient, 32 fractional bits |
| mat_en_wr | input | 1 | Write strobe for the shadow matrix enable |
| mat_en_val | input | 1 | Value for the shadow matrix enable |
| frame_start | input | 1 | Copies the shadow set to the active set |
| pix_in_vld | input | 1 | Input pixel valid |
| pix_in | input | 24 | Input pixel, RGB |
| pix_out_vld | output | 1 | Output pixel valid |
| pix_out | output | 24 | Output pixel, RGB |

## Verification
The bench targets coefficients just beyond the representable range, such as 2.0 and much larger magnitudes of both signs. A converter that truncates instead of saturating would turn these into zero or into a flipped sign, and the red result would collapse. It checks row sums that go negative and sums above 255. Wrapping arithmetic would show up there as bright or dark speckles. It loads the shadow set without a frame-start strobe, which would expose a design that applies writes at once. It also writes coefficient indices 9 to 15 and table select 3, which would expose a design that aliases them onto real entries. A long random phase runs continuously: pixels with gaps, table writes, coefficient writes and frame strobes all land mid-stream. Every clock it is compared against a behavioural model. An off-by-one in latency, or any mix-up between shadow and active settings, would mismatch within a few cycles.

// File: rtl/clrx_pkg.sv
package clrx_pkg;
    localparam int COMP_W     = 8;
    localparam int NCOMP      = 3;
    localparam int PIX_W      = COMP_W * NCOMP;
    localparam int LUT_DEPTH  = 2 ** COMP_W;
    localparam int SEL_W      = $clog2(NCOMP + 1);
    localparam int COEF_W     = 10;
    localparam int COEF_FRAC  = 8;
    localparam int COEF_MAX   = 2 ** (COEF_W - 1) - 1;
    localparam int NCOEF      = NCOMP * NCOMP;
    localparam int IDX_W      = $clog2(NCOEF);
    localparam int WIDE_W     = 64;
    localparam int WIDE_FRAC  = 32;
    localparam int WIDE_SHIFT = WIDE_FRAC - COEF_FRAC;
    localparam int PROD_W     = COEF_W + COMP_W + 1;
    localparam int SUM_W      = PROD_W + $clog2(NCOMP) + 1;
    localparam int COMP_MAX   = 2 ** COMP_W - 1;

    typedef logic [0:NCOMP-1][COMP_W-1:0] pix_t;
    typedef logic signed [COEF_W-1:0]     coef_t;
    typedef logic signed [PROD_W-1:0]     prod_t;
    typedef logic signed [SUM_W-1:0]      sum_t;
    typedef coef_t [0:NCOEF-1]            coef_set_t;
endpackage

// File: rtl/clrx_coef_sat.sv
module clrx_coef_sat
    import clrx_pkg::*;
(
    input  logic [WIDE_W-1:0] wide_i,
    output coef_t             coef_o
);
    logic [WIDE_W-2:0] mag_full;
    logic [COEF_W-2:0] mag_sat;

    always_comb begin
        mag_full = wide_i[WIDE_W-2:0] >> WIDE_SHIFT;
        if (mag_full > (WIDE_W-1)'(COEF_MAX))
            mag_sat = (COEF_W-1)'(COEF_MAX);
        else
            mag_sat = mag_full[COEF_W-2:0];
        coef_o = wide_i[WIDE_W-1] ? -$signed({1'b0, mag_sat}) : $signed({1'b0, mag_sat});
    end

    always_comb begin
        if (mag_full > (WIDE_W-1)'(COEF_MAX))
            AST_SAT_LIMIT: assert ((coef_o == coef_t'(COEF_MAX)) || (coef_o == -coef_t'(COEF_MAX))); // R4
        if (wide_i[WIDE_W-1] && (mag_full != '0))
            AST_SIGN_KEPT: assert (coef_o < 0); // R4
    end
endmodule

// File: rtl/clrx_gamma_lut.sv
module clrx_gamma_lut
    import clrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [COMP_W-1:0] wr_addr,
    input  logic [COMP_W-1:0] wr_data,
    input  logic              in_vld,
    input  pix_t              in_pix,
    output logic              out_vld,
    output pix_t              out_pix
);
    typedef struct packed {
        logic [0:NCOMP-1][LUT_DEPTH-1:0][COMP_W-1:0] tbl;
        logic                                        vld;
        pix_t                                        pix;
    } lut_st_t;

    lut_st_t st_d, st_q;
    logic    wr_hit;

    assign wr_hit = wr_en && (wr_sel < SEL_W'(NCOMP));

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        for (int k = 0; k < NCOMP; k++)
            st_d.pix[k] = st_q.tbl[k][in_pix[k]];
        if (wr_hit)
            st_d.tbl[wr_sel][wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vld <= 1'b0;
            st_q.pix <= '0;
            for (int k = 0; k < NCOMP; k++)
                for (int i = 0; i < LUT_DEPTH; i++)
                    st_q.tbl[k][i] <= COMP_W'(i);
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign out_pix = st_q.pix;

    AST_LUT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (st_q.tbl[$past(wr_sel)][$past(wr_addr)] == $past(wr_data))); // R2
    AST_LUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(st_q.tbl)); // R2
endmodule

// File: rtl/clrx_matrix.sv
module clrx_matrix
    import clrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             coef_we,
    input  logic [IDX_W-1:0] coef_idx,
    input  coef_t            coef_val,
    input  logic             en_we,
    input  logic             en_val,
    input  logic             frame_start,
    input  logic             in_vld,
    input  pix_t             in_gam,
    output logic             out_vld,
    output pix_t             out_pix
);
    typedef struct packed {
        coef_set_t                sh_c;
        logic                     sh_en;
        coef_set_t                act_c;
        logic                     act_en;
        logic                     s2_vld;
        logic                     s2_en;
        pix_t                     s2_gam;
        logic [0:NCOEF-1][PROD_W-1:0] s2_prod;
        logic                     s3_vld;
        pix_t                     s3_pix;
    } mat_st_t;

    mat_st_t st_d, st_q;
    sum_t    acc;
    sum_t    shf;
    logic    coef_hit;

    assign coef_hit = coef_we && (coef_idx < IDX_W'(NCOEF));

    always_comb begin
        st_d = st_q;
        acc  = '0;
        shf  = '0;
        if (frame_start) begin
            st_d.act_c  = st_q.sh_c;
            st_d.act_en = st_q.sh_en;
        end
        if (coef_hit)
            st_d.sh_c[coef_idx] = coef_val;
        if (en_we)
            st_d.sh_en = en_val;
        // multiply stage
        st_d.s2_vld = in_vld;
        st_d.s2_en  = st_q.act_en;
        st_d.s2_gam = in_gam;
        for (int r = 0; r < NCOMP; r++)
            for (int c = 0; c < NCOMP; c++)
                st_d.s2_prod[r*NCOMP+c] = $signed(st_q.act_c[r*NCOMP+c]) * $signed({1'b0, in_gam[c]});
        // sum and clamp stage
        st_d.s3_vld = st_q.s2_vld;
        for (int r = 0; r < NCOMP; r++) begin
            acc = '0;
            for (int c = 0; c < NCOMP; c++)
                acc = acc + sum_t'($signed(st_q.s2_prod[r*NCOMP+c]));
            shf = acc >>> COEF_FRAC;
            if (!st_q.s2_en)
                st_d.s3_pix[r] = st_q.s2_gam[r];
            else if (acc < 0)
                st_d.s3_pix[r] = '0;
            else if (shf > sum_t'(COMP_MAX))
                st_d.s3_pix[r] = '1;
            else
                st_d.s3_pix[r] = shf[COMP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_vld = st_q.s3_vld;
    assign out_pix = st_q.s3_pix;

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(st_q.act_c) && $stable(st_q.act_en))); // R7
    AST_ACTIVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> ((st_q.act_c == $past(st_q.sh_c)) && (st_q.act_en == $past(st_q.sh_en)))); // R7
    AST_SHADOW_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_hit |=> $stable(st_q.sh_c)); // R5
endmodule

// File: rtl/clrx_gamma_matrix.sv
module clrx_gamma_matrix
    import clrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lut_wr_en,
    input  logic [SEL_W-1:0]  lut_wr_sel,
    input  logic [COMP_W-1:0] lut_wr_addr,
    input  logic [COMP_W-1:0] lut_wr_data,
    input  logic              coef_wr_en,
    input  logic [IDX_W-1:0]  coef_wr_idx,
    input  logic [WIDE_W-1:0] coef_wr_val,
    input  logic              mat_en_wr,
    input  logic              mat_en_val,
    input  logic              frame_start,
    input  logic              pix_in_vld,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              pix_out_vld,
    output logic [PIX_W-1:0]  pix_out
);
    pix_t  pin, gam_pix, mat_pix;
    logic  gam_vld;
    coef_t coef_n;

    assign pin = pix_in;

    clrx_coef_sat u_sat (
        .wide_i (coef_wr_val),
        .coef_o (coef_n)
    );

    clrx_gamma_lut u_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lut_wr_en),
        .wr_sel  (lut_wr_sel),
        .wr_addr (lut_wr_addr),
        .wr_data (lut_wr_data),
        .in_vld  (pix_in_vld),
        .in_pix  (pin),
        .out_vld (gam_vld),
        .out_pix (gam_pix)
    );

    clrx_matrix u_mat (
        .clk         (clk),
        .rst_n       (rst_n),
        .coef_we     (coef_wr_en),
        .coef_idx    (coef_wr_idx),
        .coef_val    (coef_n),
        .en_we       (mat_en_wr),
        .en_val      (mat_en_val),
        .frame_start (frame_start),
        .in_vld      (gam_vld),
        .in_gam      (gam_pix),
        .out_vld     (pix_out_vld),
        .out_pix     (mat_pix)
    );

    assign pix_out = mat_pix;

    // cycles since reset, saturating; lets the latency check look back safely
    logic [1:0] age_d, age_q;
    assign age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (pix_out_vld == $past(pix_in_vld, 3))); // R9
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd0) |-> !pix_out_vld); // R3
endmodule

// File: tb/tb_clrx_gamma_matrix.sv
module tb_clrx_gamma_matrix;
    import clrx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lut_wr_en = 1'b0;
    logic [1:0]  lut_wr_sel = '0;
    logic [7:0]  lut_wr_addr = '0;
    logic [7:0]  lut_wr_data = '0;
    logic        coef_wr_en = 1'b0;
    logic [3:0]  coef_wr_idx = '0;
    logic [63:0] coef_wr_val = '0;
    logic        mat_en_wr = 1'b0;
    logic        mat_en_val = 1'b0;
    logic        frame_start = 1'b0;
    logic        pix_in_vld = 1'b0;
    logic [23:0] pix_in = '0;
    logic        pix_out_vld;
    logic [23:0] pix_out;

    localparam logic [63:0] ONE  = 64'h0000_0001_0000_0000;
    localparam logic [63:0] HALF = 64'h0000_0000_8000_0000;
    localparam logic [63:0] NEG  = 64'h8000_0000_0000_0000;

    always #2 clk = ~clk;

    clrx_gamma_matrix dut (.*);

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    run_cmp = 1'b0;
    string cur_req = "R3";

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_lut[3][256];
    int m_sh[9];
    int m_ac[9];
    bit m_sh_en, m_ac_en;
    bit m1v, m2v, m3v;
    int m1[3], m2[3], m3[3];

    function automatic int conv(input logic [63:0] w);
        longint unsigned m;
        m = w[62:0];
        m = m >> 24;
        if (m > 511) m = 511;
        return w[63] ? -int'(m) : int'(m);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) for (int i = 0; i < 256; i++) m_lut[k][i] = i;
            for (int i = 0; i < 9; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
            m_sh_en = 0; m_ac_en = 0;
            m1v = 0; m2v = 0; m3v = 0;
            for (int k = 0; k < 3; k++) begin m1[k] = 0; m2[k] = 0; m3[k] = 0; end
        end else begin
            m3v = m2v; m3 = m2;
            m2v = m1v;
            for (int r = 0; r < 3; r++) begin
                if (m_ac_en) begin
                    int acc;
                    acc = m_ac[r*3] * m1[0] + m_ac[r*3+1] * m1[1] + m_ac[r*3+2] * m1[2];
                    acc = acc >>> 8;
                    m2[r] = (acc < 0) ? 0 : (acc > 255) ? 255 : acc;
                end else begin
                    m2[r] = m1[r];
                end
            end
            m1v = pix_in_vld;
            for (int k = 0; k < 3; k++) m1[k] = m_lut[k][pix_in[23-8*k -: 8]];
            if (frame_start) begin m_ac = m_sh; m_ac_en = m_sh_en; end
            if (coef_wr_en && coef_wr_idx < 9) m_sh[coef_wr_idx] = conv(coef_wr_val);
            if (mat_en_wr) m_sh_en = mat_en_val;
            if (lut_wr_en && lut_wr_sel < 3) m_lut[lut_wr_sel][lut_wr_addr] = lut_wr_data;
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_cmp && !done) begin
            chk("R9", {31'd0, pix_out_vld}, {31'd0, m3v});
            if (m3v) chk(cur_req, {8'd0, pix_out}, 32'((m3[0] << 16) | (m3[1] << 8) | m3[2]));
        end
    end

    // ---------------- stimulus tasks (called at a falling edge) ----------------
    task automatic wr_coef(input int idx, input logic [63:0] w);
        coef_wr_en = 1; coef_wr_idx = 4'(idx); coef_wr_val = w;
        @(negedge clk); coef_wr_en = 0;
    endtask

    task automatic wr_en(input bit v);
        mat_en_wr = 1; mat_en_val = v;
        @(negedge clk); mat_en_wr = 0;
    endtask

    task automatic fstart();
        frame_start = 1;
        @(negedge clk); frame_start = 0;
    endtask

    task automatic wr_lut(input int sel, input int a, input int d);
        lut_wr_en = 1; lut_wr_sel = 2'(sel); lut_wr_addr = 8'(a); lut_wr_data = 8'(d);
        @(negedge clk); lut_wr_en = 0;
    endtask

    task automatic px_expect(input logic [23:0] p, input logic [23:0] e, input string req);
        pix_in = p; pix_in_vld = 1;
        @(negedge clk); pix_in_vld = 0;
        @(negedge clk);
        @(negedge clk);
        chk(req, {31'd0, pix_out_vld}, 32'd1);
        chk(req, {8'd0, pix_out}, {8'd0, e});
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R3", {31'd0, pix_out_vld}, 32'd0);           // R3 valid low in reset
        rst_n = 1;
        @(negedge clk);
        run_cmp = 1;

        // R3: identity tables, matrix off after reset
        px_expect(24'hA1B2C3, 24'hA1B2C3, "R3");

        // R7: shadow writes without a strobe leave pixels alone
        cur_req = "R7";
        wr_coef(1, ONE); wr_coef(5, ONE); wr_coef(6, ONE); wr_en(1);
        px_expect(24'h123456, 24'h123456, "R7");
        // R5: rotation after strobe, row-major order
        fstart();
        cur_req = "R5";
        px_expect(24'h123456, 24'h345612, "R5");

        // R4: saturation of 2.0 and of huge magnitudes
        cur_req = "R4";
        wr_coef(0, 64'h0000_0002_0000_0000); wr_coef(1, '0); fstart();
        px_expect(24'h640000, 24'hC70064, "R4");
        wr_coef(0, 64'h0000_1234_0000_0000); fstart();
        px_expect(24'h640000, 24'hC70064, "R4");
        wr_coef(0, NEG | 64'h0000_0002_0000_0000); fstart();
        px_expect(24'h640000, 24'h000064, "R4");

        // R6: signed sums, clamps and floor
        cur_req = "R6";
        wr_coef(0, ONE); wr_coef(1, NEG | HALF); fstart();
        px_expect(24'hC80A00, 24'hC300C8, "R6");
        px_expect(24'h0AC800, 24'h00000A, "R6");
        wr_coef(0, 64'h0000_0001_8000_0000); wr_coef(1, '0); fstart();
        px_expect(24'hFF0000, 24'hFF00FF, "R6");
        wr_coef(0, HALF); fstart();
        px_expect(24'h030000, 24'h010003, "R6");

        // R5: indices 9..15 ignored
        cur_req = "R5";
        for (int i = 9; i < 16; i++) wr_coef(i, ONE);
        fstart();
        px_expect(24'h030000, 24'h010003, "R5");

        // R8: disabled matrix passes gamma output
        cur_req = "R8";
        wr_en(0); fstart();
        px_expect(24'h123456, 24'h123456, "R8");

        // R1 / R2: table programming
        cur_req = "R1";
        for (int i = 0; i < 256; i++) wr_lut(0, i, 255 - i);
        for (int i = 0; i < 256; i++) wr_lut(1, i, i >> 1);
        wr_lut(3, 5, 8'h77);
        px_expect(24'h050505, 24'hFA0205, "R2");
        px_expect(24'h80FF00, 24'h7F7F00, "R1");
        wr_lut(0, 16, 8'h99);
        px_expect(24'h100000, 24'h990000, "R2");

        // R9: random streaming with mid-stream configuration changes
        cur_req = "R9";
        for (int n = 0; n < 4000; n++) begin
            pix_in      = 24'($urandom);
            pix_in_vld  = ($urandom % 4) != 0;
            lut_wr_en   = ($urandom % 8) == 0;
            lut_wr_sel  = 2'($urandom);
            lut_wr_addr = 8'($urandom);
            lut_wr_data = 8'($urandom);
            coef_wr_en  = ($urandom % 6) == 0;
            coef_wr_idx = 4'($urandom % 10);
            coef_wr_val = {1'($urandom), 63'(longint'($urandom % 1400) << 24) | 63'($urandom % (1 << 24))};
            mat_en_wr   = ($urandom % 40) == 0;
            mat_en_val  = ($urandom % 4) != 0;
            frame_start = ($urandom % 30) == 0;
            @(negedge clk);
        end
        pix_in_vld = 0; lut_wr_en = 0; coef_wr_en = 0; mat_en_wr = 0; frame_start = 0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule